// File: doc/BRIEF.md
# 32-bit Integer Arithmetic and Logic Unit

This block is the arithmetic and logic unit of a 32-bit load/store integer datapath. It takes two 32-bit operands and a 4-bit operation code, and it returns a 32-bit result, a zero flag and a signed-overflow flag. It has no clock and no storage, so the outputs follow the inputs within the same cycle. The operation code is the low four bits of the register-form function field. The decoder upstream can therefore pass those bits through without any remapping.

Addition and subtraction use a single adder. To subtract, the unit inverts the second operand and forces the carry-in to one. The signed and unsigned forms of add and subtract produce identical results. They differ only in whether overflow is reported. The overflow flag is informational only: the block does not take an exception, and the surrounding pipeline decides how to react to it.

Top module: `int_alu`

## Requirements
- R1: Op code 0000 (signed add) and 0001 (unsigned add) both give result = (a + b) mod 2^32.
- R2: Op code 0010 (signed subtract) and 0011 (unsigned subtract) both give result = (a - b) mod 2^32.
- R3: Op codes 0100, 0101, 0110 and 0111 give bitwise a AND b, a OR b, a XOR b and NOT(a OR b), respectively.
- R4: Op code 1010 gives result 1 when a < b as two's-complement numbers, and 0 otherwise. The result stays correct when a - b overflows.
- R5: Op code 1011 gives result 1 when a < b as unsigned numbers, and 0 otherwise.
- R6: For op 0000, ovf is 1 exactly when a and b have the same sign bit (bit 31) and the sign bit of the sum differs from it.
- R7: For op 0010, ovf is 1 exactly when a and b have different sign bits and the sign bit of the difference differs from the sign bit of a.
- R8: For every op code other than 0000 and 0010, ovf is 0. This includes 0001, 0011 and 1011.
- R9: zero is 1 exactly when all 32 bits of the result are 0, for every op code.
- R10: Op codes 1000, 1001 and 1100 through 1111 give result 0 and ovf 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a | input | 32 | First operand |
| b | input | 32 | Second operand |
| op | input | 4 | Operation select (low bits of the function field) |
| result | output | 32 | Operation result |
| zero | output | 1 | High when result is all zeros |
| ovf | output | 1 | Signed overflow of add or subtract |

## Verification
Every output is combinational, so each result is due in the same cycle as its stimulus, with zero cycles of latency. The bench drives new operands and an op code on the falling edge of its sampling clock. It compares result, zero and ovf against its own behavioural model on the following rising edge, after the logic has settled. Stimulus covers directed corner operands for every op code, including the overflow boundaries and mixed-sign compares, followed by a sweep with a linear-feedback generator.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

    localparam int unsigned DATA_W = 32;
    localparam int unsigned OP_W   = 4;

    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 4'b0000,
        OP_ADDU = 4'b0001,
        OP_SUB  = 4'b0010,
        OP_SUBU = 4'b0011,
        OP_AND  = 4'b0100,
        OP_OR   = 4'b0101,
        OP_XOR  = 4'b0110,
        OP_NOR  = 4'b0111,
        OP_SLT  = 4'b1010,
        OP_SLTU = 4'b1011
    } alu_op_e;

    typedef enum logic [2:0] {
        SEL_SUM,
        SEL_LOGIC,
        SEL_SLT,
        SEL_SLTU,
        SEL_NONE
    } res_sel_e;

    typedef struct packed {
        logic     sub;        // invert b and carry in one
        logic     chk_ovf;    // report signed overflow
        res_sel_e sel;        // which result source to use
        logic [1:0] log_fn;   // 00 and, 01 or, 10 xor, 11 nor
    } alu_ctrl_t;

    typedef struct packed {
        word_t sum;
        logic  cout;
        logic  sovf;
    } add_out_t;

    function automatic alu_ctrl_t decode_op(input logic [OP_W-1:0] code);
        alu_ctrl_t c;
        c.sub     = 1'b0;
        c.chk_ovf = 1'b0;
        c.sel     = SEL_NONE;
        c.log_fn  = code[1:0];
        case (code)
            OP_ADD:  begin c.sel = SEL_SUM; c.chk_ovf = 1'b1; end
            OP_ADDU: begin c.sel = SEL_SUM; end
            OP_SUB:  begin c.sel = SEL_SUM; c.sub = 1'b1; c.chk_ovf = 1'b1; end
            OP_SUBU: begin c.sel = SEL_SUM; c.sub = 1'b1; end
            OP_AND, OP_OR, OP_XOR, OP_NOR: c.sel = SEL_LOGIC;
            OP_SLT:  begin c.sel = SEL_SLT;  c.sub = 1'b1; end
            OP_SLTU: begin c.sel = SEL_SLTU; c.sub = 1'b1; end
            default: c.sel = SEL_NONE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/int_alu_adder.sv
module int_alu_adder
    import int_alu_pkg::*;
#(
    parameter int unsigned WIDTH = DATA_W
) (
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  logic             sub,
    output logic [WIDTH-1:0] sum,
    output logic             cout,
    output logic             sovf
);
    localparam int unsigned MSB = WIDTH - 1;

    logic [WIDTH-1:0] b_eff;
    logic [WIDTH:0]   carry;

    assign carry[0] = sub;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign b_eff[i]    = opb[i] ^ sub;
        assign sum[i]      = opa[i] ^ b_eff[i] ^ carry[i];
        assign carry[i+1]  = (opa[i] & b_eff[i]) | (opa[i] & carry[i]) | (b_eff[i] & carry[i]);
    end

    assign cout = carry[WIDTH];
    // operands as seen by the adder share a sign that the sum lacks
    assign sovf = (opa[MSB] == b_eff[MSB]) && (sum[MSB] != opa[MSB]);
endmodule

// File: rtl/int_alu_logic.sv
module int_alu_logic
    import int_alu_pkg::*;
#(
    parameter int unsigned WIDTH = DATA_W
) (
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  logic [1:0]       fn,
    output logic [WIDTH-1:0] res
);
    always_comb begin
        case (fn)
            2'b00:   res = opa & opb;
            2'b01:   res = opa | opb;
            2'b10:   res = opa ^ opb;
            default: res = ~(opa | opb);
        endcase
    end
endmodule

// File: rtl/int_alu.sv
module int_alu
    import int_alu_pkg::*;
(
    input  logic [31:0] a,
    input  logic [31:0] b,
    input  logic [3:0]  op,
    output logic [31:0] result,
    output logic        zero,
    output logic        ovf
);
    localparam int unsigned MSB = DATA_W - 1;

    alu_ctrl_t ctrl;
    add_out_t  add_o;
    word_t     logic_res;
    word_t     res_mux;

    assign ctrl = decode_op(op);

    int_alu_adder #(.WIDTH(DATA_W)) u_adder (
        .opa  (a),
        .opb  (b),
        .sub  (ctrl.sub),
        .sum  (add_o.sum),
        .cout (add_o.cout),
        .sovf (add_o.sovf)
    );

    int_alu_logic #(.WIDTH(DATA_W)) u_logic (
        .opa (a),
        .opb (b),
        .fn  (ctrl.log_fn),
        .res (logic_res)
    );

    always_comb begin
        res_mux = '0;
        case (ctrl.sel)
            SEL_SUM:   res_mux = add_o.sum;
            SEL_LOGIC: res_mux = logic_res;
            SEL_SLT:   res_mux = {{MSB{1'b0}}, add_o.sum[MSB] ^ add_o.sovf};
            SEL_SLTU:  res_mux = {{MSB{1'b0}}, ~add_o.cout};
            default:   res_mux = '0;
        endcase
    end

    assign result = res_mux;
    assign zero   = (res_mux == '0);
    assign ovf    = ctrl.chk_ovf & add_o.sovf;
endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk (
    input logic [31:0] a,
    input logic [31:0] b,
    input logic [3:0]  op,
    input logic [31:0] result,
    input logic        zero,
    input logic        ovf
);
    always_comb begin
        if (!$isunknown({a, b, op})) begin
            AST_ZERO_FLAG: assert (zero == (result == 32'd0)); // R9
            AST_NO_OVERFLOW: assert ((op == 4'b0000 || op == 4'b0010) || !ovf); // R8
            AST_ADD_OVF: assert (op != 4'b0000 || ovf == ((a[31] == b[31]) && (result[31] != a[31]))); // R6
            AST_SUB_OVF: assert (op != 4'b0010 || ovf == ((a[31] != b[31]) && (result[31] != a[31]))); // R7
            AST_CMP_BIT: assert (!(op == 4'b1010 || op == 4'b1011) || result[31:1] == 31'd0); // R4
            AST_UNUSED_OP: assert (!(op == 4'b1000 || op == 4'b1001 || op[3:2] == 2'b11) || result == 32'd0); // R10
        end
    end
endmodule

bind int_alu int_alu_chk u_chk (
    .a(a), .b(b), .op(op), .result(result), .zero(zero), .ovf(ovf)
);

// File: tb/int_alu_tb_top.sv
module int_alu_tb_top;
    logic        clk = 1'b0;
    logic [31:0] a, b;
    logic [3:0]  op;
    logic [31:0] result;
    logic        zero, ovf;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    int_alu dut_i (.a(a), .b(b), .op(op), .result(result), .zero(zero), .ovf(ovf));

    function automatic void model(input logic [31:0] x, input logic [31:0] y, input logic [3:0] o,
                                  output logic [31:0] r, output logic v);
        longint sx, sy, s;
        sx = longint'($signed(x));
        sy = longint'($signed(y));
        r = 32'd0; v = 1'b0;
        case (o)
            4'd0: begin s = sx + sy; r = x + y; v = (s > 64'sd2147483647) || (s < -64'sd2147483648); end
            4'd1: r = x + y;
            4'd2: begin s = sx - sy; r = x - y; v = (s > 64'sd2147483647) || (s < -64'sd2147483648); end
            4'd3: r = x - y;
            4'd4: r = x & y;
            4'd5: r = x | y;
            4'd6: r = x ^ y;
            4'd7: r = ~(x | y);
            4'd10: r = (sx < sy) ? 32'd1 : 32'd0;
            4'd11: r = (x < y) ? 32'd1 : 32'd0;
            default: r = 32'd0;
        endcase
    endfunction

    function automatic string tag(input logic [3:0] o);
        case (o)
            4'd0, 4'd1: return "R1";
            4'd2, 4'd3: return "R2";
            4'd4, 4'd5, 4'd6, 4'd7: return "R3";
            4'd10: return "R4";
            4'd11: return "R5";
            default: return "R10";
        endcase
    endfunction

    task automatic apply(input logic [31:0] x, input logic [31:0] y, input logic [3:0] o);
        logic [31:0] er;
        logic ev;
        @(negedge clk);
        a = x; b = y; op = o;
        @(posedge clk);
        #1;
        model(x, y, o, er, ev);
        n_chk++;
        if (result !== er) begin
            n_bad++;
            $display("FAIL %s op=%0d a=%h b=%h result actual=%h expected=%h", tag(o), o, x, y, result, er);
        end
        n_chk++;
        if (ovf !== ev) begin
            n_bad++;
            $display("FAIL %s op=%0d a=%h b=%h ovf actual=%b expected=%b",
                     (o == 4'd0) ? "R6" : (o == 4'd2) ? "R7" : "R8", o, x, y, ovf, ev);
        end
        n_chk++;
        if (zero !== (er == 32'd0)) begin
            n_bad++;
            $display("FAIL R9 op=%0d zero actual=%b expected=%b", o, zero, er == 32'd0);
        end
    endtask

    initial begin
        logic [31:0] lf;
        a = '0; b = '0; op = '0;
        @(posedge clk);
        #1;
        n_chk++; // reset-state equivalent: all-zero inputs give zero result and flag (R9)
        if (result !== 32'd0 || zero !== 1'b1 || ovf !== 1'b0) begin
            n_bad++;
            $display("FAIL R9 idle result actual=%h expected=0 zero=%b", result, zero);
        end
        // R1 / R6 corners
        apply(32'h7FFFFFFF, 32'h1, 4'd0);
        apply(32'h7FFFFFFF, 32'h1, 4'd1);
        apply(32'h80000000, 32'h80000000, 4'd0);
        apply(32'hFFFFFFFF, 32'h1, 4'd0);
        apply(32'h7FFFFFFF, 32'h80000000, 4'd0);
        // R2 / R7 corners
        apply(32'h80000000, 32'h1, 4'd2);
        apply(32'h80000000, 32'h1, 4'd3);
        apply(32'h7FFFFFFF, 32'hFFFFFFFF, 4'd2);
        apply(32'h5, 32'h5, 4'd2);
        apply(32'h0, 32'h80000000, 4'd2);
        // R3
        apply(32'hF0F0A5A5, 32'h0FF05A5A, 4'd4);
        apply(32'hF0F0A5A5, 32'h0FF05A5A, 4'd5);
        apply(32'hF0F0A5A5, 32'h0FF05A5A, 4'd6);
        apply(32'hF0F0A5A5, 32'h0FF05A5A, 4'd7);
        apply(32'hFFFFFFFF, 32'h0, 4'd7);
        // R4 / R5
        apply(32'h80000000, 32'h1, 4'd10);
        apply(32'h80000000, 32'h1, 4'd11);
        apply(32'h7FFFFFFF, 32'h80000000, 4'd10);
        apply(32'h7FFFFFFF, 32'h80000000, 4'd11);
        apply(32'h3, 32'h3, 4'd10);
        apply(32'h3, 32'h3, 4'd11);
        apply(32'hFFFFFFFE, 32'hFFFFFFFF, 4'd10);
        // R8: unsigned forms with overflowing operands
        apply(32'h80000000, 32'h80000000, 4'd1);
        apply(32'h80000000, 32'h7FFFFFFF, 4'd3);
        apply(32'h80000000, 32'h7FFFFFFF, 4'd11);
        // R10 unused codes
        for (int k = 8; k < 16; k++)
            if (k != 10 && k != 11) apply(32'hDEADBEEF, 32'h12345678, 4'(k));
        // sweep
        lf = 32'hACE12345;
        for (int i = 0; i < 400; i++) begin
            logic [31:0] x, y;
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            x = lf;
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            y = (i % 7 == 0) ? x : lf;
            apply(x, y, 4'(i % 16));
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog expired actual=running expected=done");
            end
        join_any
        disable fork;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule